// File: doc/BRIEF.md
# GPIO Edge Interrupt Aggregator

This block watches a set of general-purpose input pins, organised as banks of 32, and turns selected signal transitions into interrupt requests. Each pin can be armed for rising transitions, falling transitions or both. Arming goes through paired set and clear words, so software never needs a read-modify-write. An armed transition latches a sticky status bit. Software clears status bits by writing ones to them.

Every 16-pin half of a bank owns one interrupt line. A line follows the OR of its status bits, masked by a global per-group enable word. As an option, the lowest pins of bank 0 can each drive a dedicated interrupt output instead of feeding their group line. Pins are first brought into the clock domain through a synchronizer chain. A transition is then found by comparing the synchronized value with the value it had one clock earlier.

Software accesses the block through a flat register port. Writes take effect on a single-cycle strobe, and reads are combinational from the address.

Top module: `gpio_edge_irq`

## Requirements
- R1: After reset, all arming bits, all status bits and the group enable word are zero, every read returns zero, and every interrupt output is low.
- R2: Bank b occupies addresses starting at 0x10 + 0x28*b. Writing ones at +0x14 arms rising detection for those pins and at +0x18 disarms it. Writing ones at +0x1C arms falling detection and at +0x20 disarms it. Zero bits leave arming unchanged. Reading either word of a pair returns the current arming. Any other bank offset reads as zero.
- R3: A 0-to-1 change of a pin latches that pin's status bit, at bank offset +0x24 with bit n for pin 32*b+n, only while rising detection is armed for the pin.
- R4: A 1-to-0 change latches the status bit only while falling detection is armed. With both directions armed, either transition latches it.
- R5: Writing a 1 to a status bit clears it. Writing a 0 leaves it unchanged.
- R6: When a pin transition and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R7: Group line g, where grp_irq[g] covers flat pins 16g to 16g+15, is a register. It goes high one clock after both a status bit of its group and enable bit g are set. The two halves of a bank drive separate lines.
- R8: The group enable word at address 0x08 holds bit g for line g and reads back as written. A line stays low while its bit is clear, even when its status bits are set.
- R9: In direct mode, status bit i of bank 0 for i below DIRECT_N drives direct_irq[i] one clock later, gated by the enable bit of group 0. These pins do not contribute to group line 0.
- R10: Pin inputs pass through SYNC_STAGES flip-flops. With the default of two stages, a status bit reads set after the third rising clock edge following the pin change, and not after the second.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| gpio_in | input | NUM_BANKS*BANK_W | Asynchronous pin levels, flat index 32*bank+bit |
| reg_wr | input | 1 | Single-cycle write strobe |
| reg_addr | input | ADDR_W | Byte address for reads and writes |
| reg_wdata | input | BANK_W | Write data |
| reg_rdata | output | BANK_W | Read data for reg_addr, combinational |
| grp_irq | output | NUM_BANKS*BANK_W/GROUP_W | One registered interrupt line per 16-pin group |
| direct_irq | output | DIRECT_N | Dedicated lines for the lowest bank-0 pins in direct mode, zero otherwise |

## Verification
The bound checker watches several rules on every clock. It checks that each armed transition leaves its status bit set, including under a simultaneous clear. It checks that a status bit drops only after a write naming it, that arming changes only after a write to the bank's arming words, and that no group or direct line rises without an enable bit and a status source. The directed scenarios cover what those invariants cannot show. These are the exact synchronizer latency, the one-cycle lag of the registered lines, the readback of the address map, writes of zeros having no effect, the split of bank halves onto separate lines, and the removal of direct pins from their group.

// File: rtl/gei_pkg.sv
`timescale 1ns/1ps
package gei_pkg;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_RISE_SET,
      SEL_RISE_CLR,
      SEL_FALL_SET,
      SEL_FALL_CLR,
      SEL_STATUS
   } bank_sel_e;

   localparam logic [15:0] GRP_EN_ADDR  = 16'h0008;
   localparam logic [15:0] BANK0_BASE   = 16'h0010;
   localparam logic [15:0] BANK_STRIDE  = 16'h0028;
   localparam logic [15:0] REL_RISE_SET = 16'h0014;
   localparam logic [15:0] REL_RISE_CLR = 16'h0018;
   localparam logic [15:0] REL_FALL_SET = 16'h001C;
   localparam logic [15:0] REL_FALL_CLR = 16'h0020;
   localparam logic [15:0] REL_STATUS   = 16'h0024;

   function automatic logic [15:0] bank_base(input int b);
      return BANK0_BASE + BANK_STRIDE * 16'(b);
   endfunction

   function automatic bank_sel_e decode_sel(input logic [15:0] addr, input int b);
      logic [15:0] base;
      base = bank_base(b);
      if (addr == base + REL_RISE_SET)      return SEL_RISE_SET;
      else if (addr == base + REL_RISE_CLR) return SEL_RISE_CLR;
      else if (addr == base + REL_FALL_SET) return SEL_FALL_SET;
      else if (addr == base + REL_FALL_CLR) return SEL_FALL_CLR;
      else if (addr == base + REL_STATUS)   return SEL_STATUS;
      else                                  return SEL_NONE;
   endfunction

endpackage

// File: rtl/gei_sync.sv
`timescale 1ns/1ps
module gei_sync #(
   parameter int W      = 64,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (STAGES < 1) begin : g_bad
         $error("gei_sync: STAGES must be at least 1");
      end

      if (STAGES == 1) begin : g_single
         logic [W-1:0] stage_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q <= '0;
            else        stage_q <= d;
         end
         assign q = stage_q;
      end else begin : g_chain
         logic [W-1:0] chain_q [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) chain_q[i] <= '0;
            end else begin
               chain_q[0] <= d;
               for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
            end
         end
         assign q = chain_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/gei_bank.sv
`timescale 1ns/1ps
module gei_bank
   import gei_pkg::*;
#(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] pin_s,
   input  bank_sel_e    wr_sel,
   input  logic [W-1:0] wr_data,
   output logic [W-1:0] rise_en,
   output logic [W-1:0] fall_en,
   output logic [W-1:0] status
);

   logic [W-1:0] prev_q;
   logic [W-1:0] rise_hit;
   logic [W-1:0] fall_hit;
   logic [W-1:0] clr_bits;
   logic [W-1:0] rise_nxt;
   logic [W-1:0] fall_nxt;
   logic [W-1:0] stat_nxt;

   assign rise_hit = pin_s & ~prev_q & rise_en;
   assign fall_hit = ~pin_s & prev_q & fall_en;
   assign clr_bits = (wr_sel == SEL_STATUS) ? wr_data : '0;

   always_comb begin
      rise_nxt = rise_en;
      fall_nxt = fall_en;
      unique case (wr_sel)
         SEL_RISE_SET: rise_nxt = rise_en | wr_data;
         SEL_RISE_CLR: rise_nxt = rise_en & ~wr_data;
         SEL_FALL_SET: fall_nxt = fall_en | wr_data;
         SEL_FALL_CLR: fall_nxt = fall_en & ~wr_data;
         default: ;
      endcase
      // a fresh transition outranks a clearing write
      stat_nxt = (status & ~clr_bits) | rise_hit | fall_hit;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q  <= '0;
         rise_en <= '0;
         fall_en <= '0;
         status  <= '0;
      end else begin
         prev_q  <= pin_s;
         rise_en <= rise_nxt;
         fall_en <= fall_nxt;
         status  <= stat_nxt;
      end
   end

endmodule

// File: rtl/gei_irq_out.sv
`timescale 1ns/1ps
module gei_irq_out #(
   parameter int NUM_BANKS   = 2,
   parameter int BANK_W      = 32,
   parameter int GROUP_W     = 16,
   parameter bit DIRECT_MODE = 1'b1,
   parameter int DIRECT_N    = 4,
   localparam int TOTAL      = NUM_BANKS * BANK_W,
   localparam int NUM_GROUPS = TOTAL / GROUP_W
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [TOTAL-1:0]      status,
   input  logic [NUM_GROUPS-1:0] grp_en,
   output logic [NUM_GROUPS-1:0] grp_irq,
   output logic [DIRECT_N-1:0]   direct_irq
);

   logic [TOTAL-1:0] grp_mask;

   generate
      if (DIRECT_MODE) begin : g_direct
         assign grp_mask = (TOTAL'(1) << DIRECT_N) - TOTAL'(1);
         for (genvar i = 0; i < DIRECT_N; i++) begin : g_pin
            localparam int GI = i / GROUP_W;
            logic line_q;
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) line_q <= 1'b0;
               else        line_q <= status[i] & grp_en[GI];
            end
            assign direct_irq[i] = line_q;
         end
      end else begin : g_banked
         assign grp_mask   = '0;
         assign direct_irq = '0;
      end

      for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
         logic line_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) line_q <= 1'b0;
            else        line_q <= (|(status[g*GROUP_W +: GROUP_W] &
                                     ~grp_mask[g*GROUP_W +: GROUP_W])) & grp_en[g];
         end
         assign grp_irq[g] = line_q;
      end
   endgenerate

endmodule

// File: rtl/gpio_edge_irq.sv
`timescale 1ns/1ps
module gpio_edge_irq
   import gei_pkg::*;
#(
   parameter int NUM_BANKS   = 2,
   parameter int BANK_W      = 32,
   parameter int GROUP_W     = 16,
   parameter int SYNC_STAGES = 2,
   parameter bit DIRECT_MODE = 1'b1,
   parameter int DIRECT_N    = 4,
   parameter int ADDR_W      = 8,
   localparam int TOTAL      = NUM_BANKS * BANK_W,
   localparam int NUM_GROUPS = TOTAL / GROUP_W
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [TOTAL-1:0]      gpio_in,
   input  logic                  reg_wr,
   input  logic [ADDR_W-1:0]     reg_addr,
   input  logic [BANK_W-1:0]     reg_wdata,
   output logic [BANK_W-1:0]     reg_rdata,
   output logic [NUM_GROUPS-1:0] grp_irq,
   output logic [DIRECT_N-1:0]   direct_irq
);

   localparam int LAST_ADDR = 16 + 40 * NUM_BANKS;

   generate
      if (BANK_W % GROUP_W != 0) begin : g_chk_grp
         $error("gpio_edge_irq: GROUP_W must divide BANK_W");
      end
      if (NUM_GROUPS > BANK_W) begin : g_chk_gen
         $error("gpio_edge_irq: group enable word wider than BANK_W");
      end
      if (DIRECT_N < 1 || DIRECT_N > BANK_W) begin : g_chk_dir
         $error("gpio_edge_irq: DIRECT_N out of range");
      end
      if (ADDR_W > 16 || LAST_ADDR > (1 << ADDR_W)) begin : g_chk_addr
         $error("gpio_edge_irq: ADDR_W too small for the bank map");
      end
   endgenerate

   logic [15:0]           addr16;
   logic [TOTAL-1:0]      pin_sync;
   logic [TOTAL-1:0]      rise_all;
   logic [TOTAL-1:0]      fall_all;
   logic [TOTAL-1:0]      stat_all;
   logic [NUM_GROUPS-1:0] gen_q;

   assign addr16 = 16'(reg_addr);

   gei_sync #(
      .W      (TOTAL),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (gpio_in),
      .q     (pin_sync)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                gen_q <= '0;
      else if (reg_wr && addr16 == GRP_EN_ADDR)  gen_q <= reg_wdata[NUM_GROUPS-1:0];
   end

   generate
      for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
         bank_sel_e sel;
         assign sel = reg_wr ? decode_sel(addr16, b) : SEL_NONE;

         gei_bank #(
            .W (BANK_W)
         ) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .pin_s   (pin_sync[b*BANK_W +: BANK_W]),
            .wr_sel  (sel),
            .wr_data (reg_wdata),
            .rise_en (rise_all[b*BANK_W +: BANK_W]),
            .fall_en (fall_all[b*BANK_W +: BANK_W]),
            .status  (stat_all[b*BANK_W +: BANK_W])
         );
      end
   endgenerate

   always_comb begin
      reg_rdata = '0;
      if (addr16 == GRP_EN_ADDR) reg_rdata[NUM_GROUPS-1:0] = gen_q;
      for (int b = 0; b < NUM_BANKS; b++) begin
         unique case (decode_sel(addr16, b))
            SEL_RISE_SET, SEL_RISE_CLR: reg_rdata = rise_all[b*BANK_W +: BANK_W];
            SEL_FALL_SET, SEL_FALL_CLR: reg_rdata = fall_all[b*BANK_W +: BANK_W];
            SEL_STATUS:                 reg_rdata = stat_all[b*BANK_W +: BANK_W];
            default: ;
         endcase
      end
   end

   gei_irq_out #(
      .NUM_BANKS   (NUM_BANKS),
      .BANK_W      (BANK_W),
      .GROUP_W     (GROUP_W),
      .DIRECT_MODE (DIRECT_MODE),
      .DIRECT_N    (DIRECT_N)
   ) u_irq (
      .clk        (clk),
      .rst_n      (rst_n),
      .status     (stat_all),
      .grp_en     (gen_q),
      .grp_irq    (grp_irq),
      .direct_irq (direct_irq)
   );

endmodule

// File: rtl/gei_chk.sv
`timescale 1ns/1ps
module gei_chk
   import gei_pkg::*;
#(
   parameter int NUM_BANKS   = 2,
   parameter int BANK_W      = 32,
   parameter int GROUP_W     = 16,
   parameter bit DIRECT_MODE = 1'b1,
   parameter int DIRECT_N    = 4,
   parameter int ADDR_W      = 8,
   localparam int TOTAL      = NUM_BANKS * BANK_W,
   localparam int NUM_GROUPS = TOTAL / GROUP_W
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic [TOTAL-1:0]      gpio_sync,
   input logic [TOTAL-1:0]      rise_all,
   input logic [TOTAL-1:0]      fall_all,
   input logic [TOTAL-1:0]      stat_all,
   input logic [NUM_GROUPS-1:0] gen_q,
   input logic [NUM_GROUPS-1:0] grp_irq,
   input logic [DIRECT_N-1:0]   direct_irq,
   input logic                  reg_wr,
   input logic [ADDR_W-1:0]     reg_addr,
   input logic [BANK_W-1:0]     reg_wdata
);

   logic [TOTAL-1:0]      clr_now;
   logic [NUM_BANKS-1:0]  rwr_now, fwr_now;
   logic [TOTAL-1:0]      sync_prev, stat_prev, clr_prev, edge_q, rise_prev, fall_prev;
   logic [NUM_BANKS-1:0]  rwr_q, fwr_q;
   logic [NUM_GROUPS-1:0] gen_prev;

   always_comb begin
      clr_now = '0;
      rwr_now = '0;
      fwr_now = '0;
      for (int b = 0; b < NUM_BANKS; b++) begin
         if (reg_wr) begin
            unique case (decode_sel(16'(reg_addr), b))
               SEL_STATUS:                 clr_now[b*BANK_W +: BANK_W] = reg_wdata;
               SEL_RISE_SET, SEL_RISE_CLR: rwr_now[b] = 1'b1;
               SEL_FALL_SET, SEL_FALL_CLR: fwr_now[b] = 1'b1;
               default: ;
            endcase
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_prev <= '0; stat_prev <= '0; clr_prev <= '0; edge_q <= '0;
         rise_prev <= '0; fall_prev <= '0; rwr_q <= '0; fwr_q <= '0; gen_prev <= '0;
      end else begin
         sync_prev <= gpio_sync;
         stat_prev <= stat_all;
         clr_prev  <= clr_now;
         edge_q    <= (gpio_sync & ~sync_prev & rise_all) | (~gpio_sync & sync_prev & fall_all);
         rise_prev <= rise_all;
         fall_prev <= fall_all;
         rwr_q     <= rwr_now;
         fwr_q     <= fwr_now;
         gen_prev  <= gen_q;
      end
   end

   // R3 R4 R6
   edge_latched_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_all & edge_q) == edge_q);

   // R5
   no_spurious_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((stat_prev & ~stat_all) & ~clr_prev) == '0);

   // R8
   grp_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (grp_irq & ~gen_prev) == '0);

   generate
      for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank_chk
         // R2
         rise_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (rise_all[b*BANK_W +: BANK_W] != rise_prev[b*BANK_W +: BANK_W]) |-> rwr_q[b]);
         // R2
         fall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (fall_all[b*BANK_W +: BANK_W] != fall_prev[b*BANK_W +: BANK_W]) |-> fwr_q[b]);
      end

      for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp_chk
         // R7
         grp_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
            grp_irq[g] |-> (|stat_prev[g*GROUP_W +: GROUP_W]));
      end

      if (DIRECT_MODE) begin : g_dir_chk
         // R9
         direct_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (direct_irq & ~stat_prev[DIRECT_N-1:0]) == '0);
         // R9
         direct_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (direct_irq != '0) |-> gen_prev[0]);
      end else begin : g_nodir_chk
         // R9
         direct_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
            direct_irq == '0);
      end
   endgenerate

endmodule

bind gpio_edge_irq gei_chk #(
   .NUM_BANKS   (NUM_BANKS),
   .BANK_W      (BANK_W),
   .GROUP_W     (GROUP_W),
   .DIRECT_MODE (DIRECT_MODE),
   .DIRECT_N    (DIRECT_N),
   .ADDR_W      (ADDR_W)
) u_gei_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .gpio_sync  (pin_sync),
   .rise_all   (rise_all),
   .fall_all   (fall_all),
   .stat_all   (stat_all),
   .gen_q      (gen_q),
   .grp_irq    (grp_irq),
   .direct_irq (direct_irq),
   .reg_wr     (reg_wr),
   .reg_addr   (reg_addr),
   .reg_wdata  (reg_wdata)
);

// File: tb/test_gpio_edge_irq.sv
`timescale 1ns/1ps
module test_gpio_edge_irq;

   localparam int RS = 'h14, RC = 'h18, FS = 'h1C, FC = 'h20, ST = 'h24;
   localparam logic [7:0] GEN = 8'h08;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] gpio = '0;
   logic        reg_wr = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [3:0]  grp_irq;
   logic [3:0]  direct_irq;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   gpio_edge_irq i_gpio_edge_irq (
      .clk        (clk),
      .rst_n      (rst_n),
      .gpio_in    (gpio),
      .reg_wr     (reg_wr),
      .reg_addr   (reg_addr),
      .reg_wdata  (reg_wdata),
      .reg_rdata  (reg_rdata),
      .grp_irq    (grp_irq),
      .direct_irq (direct_irq)
   );

   function automatic logic [7:0] ra(input int b, input int rel);
      return 8'(16 + 40 * b + rel);
   endfunction

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic settle();
      repeat (5) @(negedge clk);
      #1;
   endtask

   task automatic t_reset();
      logic [31:0] d;
      #1;
      chk("R1 group lines", 32'(grp_irq), 0);
      chk("R1 direct lines", 32'(direct_irq), 0);
      rd(GEN, d);        chk("R1 group enable", d, 0);
      rd(ra(0, RS), d);  chk("R1 rise arming", d, 0);
      rd(ra(0, FC), d);  chk("R1 fall arming", d, 0);
      rd(ra(1, ST), d);  chk("R1 status", d, 0);
   endtask

   task automatic t_arming();
      logic [31:0] d;
      wr(ra(0, RS), 32'h0000_0F00);
      wr(ra(0, RS), 32'h00F0_0000);
      rd(ra(0, RS), d);  chk("R2 rise set accumulates", d, 32'h00F0_0F00);
      rd(ra(0, RC), d);  chk("R2 rise readback at clear word", d, 32'h00F0_0F00);
      wr(ra(0, RC), 32'h0000_0300);
      rd(ra(0, RS), d);  chk("R2 rise clear", d, 32'h00F0_0C00);
      wr(ra(0, FS), 32'h0000_0800);
      rd(ra(0, FC), d);  chk("R2 fall set", d, 32'h0000_0800);
      rd(8'h00, d);      chk("R2 unmapped read", d, 0);
      rd(ra(0, 'h10), d); chk("R2 unused bank offset", d, 0);
   endtask

   task automatic t_latency();
      @(negedge clk);
      reg_addr = ra(0, ST);
      gpio[10] = 1'b1;
      @(negedge clk);
      @(negedge clk);
      #1 chk("R10 not yet after two edges", reg_rdata, 0);
      @(negedge clk);
      #1 chk("R10 R3 set after third edge", reg_rdata, 32'h0000_0400);
   endtask

   task automatic t_unarmed();
      logic [31:0] d;
      @(negedge clk); gpio[12] = 1'b1;
      settle();
      rd(ra(0, ST), d);  chk("R3 unarmed rise ignored", d, 32'h0000_0400);
   endtask

   task automatic t_fall();
      logic [31:0] d;
      wr(ra(0, ST), 32'hFFFF_FFFF);
      @(negedge clk); gpio[11] = 1'b1;
      settle();
      rd(ra(0, ST), d);  chk("R4 rise on both-armed pin", d, 32'h0000_0800);
      wr(ra(0, ST), 32'hFFFF_FFFF);
      @(negedge clk); gpio[10] = 1'b0; gpio[11] = 1'b0; gpio[12] = 1'b0;
      settle();
      rd(ra(0, ST), d);  chk("R4 only fall-armed pin latches", d, 32'h0000_0800);
   endtask

   task automatic t_w1c();
      logic [31:0] d;
      wr(ra(0, ST), 32'h0);
      rd(ra(0, ST), d);  chk("R5 zero write", d, 32'h0000_0800);
      wr(ra(0, ST), 32'h0000_0400);
      rd(ra(0, ST), d);  chk("R5 other bit write", d, 32'h0000_0800);
      wr(ra(0, ST), 32'h0000_0800);
      rd(ra(0, ST), d);  chk("R5 clear", d, 0);
   endtask

   task automatic t_edge_wins();
      logic [31:0] d;
      @(negedge clk); gpio[11] = 1'b1;
      settle();
      @(negedge clk); gpio[11] = 1'b0;
      @(negedge clk);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = ra(0, ST); reg_wdata = 32'h0000_0800;
      @(negedge clk);
      reg_wr = 1'b0;
      rd(ra(0, ST), d);  chk("R6 edge beats clear", d, 32'h0000_0800);
      wr(ra(0, ST), 32'h0000_0800);
      rd(ra(0, ST), d);  chk("R6 later clear works", d, 0);
   endtask

   task automatic t_groups();
      logic [31:0] d;
      @(negedge clk); gpio[20] = 1'b1;
      settle();
      rd(ra(0, ST), d);  chk("R3 upper-half status", d, 32'h0010_0000);
      chk("R8 disabled line stays low", 32'(grp_irq), 0);
      wr(GEN, 32'h3);
      #1 chk("R7 line registered", 32'(grp_irq), 0);
      @(negedge clk);
      #1 chk("R7 upper half line", 32'(grp_irq), 32'h2);
      rd(GEN, d);        chk("R8 enable readback", d, 32'h3);
      wr(ra(0, ST), 32'h0010_0000);
      #1 chk("R7 line lags clear", 32'(grp_irq), 32'h2);
      @(negedge clk);
      #1 chk("R7 line drops", 32'(grp_irq), 0);
      @(negedge clk); gpio[10] = 1'b1;
      settle();
      chk("R7 lower half line", 32'(grp_irq), 32'h1);
      wr(ra(0, ST), 32'hFFFF_FFFF);
   endtask

   task automatic t_bank1();
      logic [31:0] d;
      wr(ra(1, RS), 32'h0002_0000);
      rd(ra(1, RC), d);  chk("R2 bank 1 arming", d, 32'h0002_0000);
      wr(GEN, 32'hB);
      @(negedge clk); gpio[49] = 1'b1;
      settle();
      chk("R7 bank 1 upper line", 32'(grp_irq), 32'h8);
      rd(ra(1, ST), d);  chk("R3 bank 1 status", d, 32'h0002_0000);
      rd(ra(0, ST), d);  chk("R3 bank 0 untouched", d, 0);
      wr(ra(1, ST), 32'hFFFF_FFFF);
   endtask

   task automatic t_direct();
      logic [31:0] d;
      wr(ra(0, RS), 32'h0000_0004);
      @(negedge clk); gpio[2] = 1'b1;
      settle();
      chk("R9 direct line", 32'(direct_irq), 32'h4);
      chk("R9 excluded from group", 32'(grp_irq), 0);
      rd(ra(0, ST), d);  chk("R9 status kept", d, 32'h0000_0004);
      wr(GEN, 32'h2);
      @(negedge clk);
      #1 chk("R9 gated by group 0 enable", 32'(direct_irq), 0);
      wr(GEN, 32'h1);
      @(negedge clk);
      #1 chk("R9 re-enabled", 32'(direct_irq), 32'h4);
      wr(ra(0, ST), 32'h0000_0004);
      @(negedge clk);
      #1 chk("R9 follows clear", 32'(direct_irq), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_arming();
      t_latency();
      t_unarmed();
      t_fall();
      t_w1c();
      t_edge_wins();
      t_groups();
      t_bank1();
      t_direct();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #800000;
      checks++;
      errors++;
      $display("FAIL R1 watchdog: actual timeout, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule